// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This block rearranges the lanes of two 64-bit operands, S and T, into one 64-bit result. A 5-bit shuffle code carries both the lane format and the pattern. The lane format is either eight 8-bit byte lanes or four 16-bit halfword lanes. The patterns interleave the two operands, pack alternating lanes, replicate half-vectors, swap lanes in a butterfly, and unpack the low bytes of S next to sign-fill bytes. Codes with no pattern behind them give a zero result and raise an illegal flag.

The selection logic is combinational. The result and the flag are captured in one output register, so they appear one clock after the code and the operands are presented. It is meant to sit in a media datapath after operand read and ahead of write-back.

Top module: `lane_shuffle`

## Requirements
- R1: The format field is code bits 1:0. With 01 the format is halfword and the pattern number is code[4:2]. With bit 0 equal to 0 the format is byte and the pattern number is code[4:1]. With 11 the code is illegal: the result is zero and the flag is set.
- R2: Halfword patterns 0 and 1 interleave a half-vector of T with the same half-vector of S, T lane first. Pattern 0 takes the upper lanes and gives T2,S2,T3,S3. Pattern 1 takes the lower lanes and gives T0,S0,T1,S1.
- R3: Halfword pattern 2 gives T1,T3,S1,S3. Halfword pattern 4 (butterfly) gives T1,S0,T3,S2.
- R4: Halfword pattern 6 gives T2,T3,S2,S3. Halfword pattern 7 gives T0,T1,S0,S1.
- R5: Halfword patterns 3 and 5 give a zero result with the illegal flag set.
- R6: Byte pattern 3 gives S0,X0,S1,X1,S2,X2,S3,X3. Each X byte is 0xFF when bit 7 of the byte of S with the same number is 1, and 0x00 when that bit is 0.
- R7: Byte pattern 4 gives T1,T3,T5,T7,S1,S3,S5,S7. Byte pattern 5 gives T0,T2,T4,T6,S0,S2,S4,S6.
- R8: Byte patterns 6 and 1 both give T4,S4,T5,S5,T6,S6,T7,S7. Byte patterns 7 and 2 both give T0,S0,T1,S1,T2,S2,T3,S3.
- R9: Byte pattern 0 and byte patterns 8 to 15 give a zero result with the illegal flag set.
- R10: The result and the flag are registered. They reflect the code and operands present at the previous rising clock edge. A synchronous active-low reset forces the result to zero and the flag low.
- R11: Lane 0 is the least significant lane of S, of T and of the result. Each lane list above runs from lane 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_i | input | 5 | Shuffle code (format and pattern) |
| s_i | input | 64 | Operand S |
| t_i | input | 64 | Operand T |
| res_o | output | 64 | Registered shuffle result |
| illegal_o | output | 1 | Registered flag: the code is reserved or malformed |

## Verification
The bench builds the block with its default width of 64 bits. That width gives eight byte lanes and four halfword lanes, so every one of the 32 codes maps onto the lane layouts the requirements list. Each code is driven with lane-numbered operands, all-ones and sign-boundary bytes, and pseudo-random words, so that every lane of every pattern is shown to come from the right source lane. Reset is also applied in the middle of traffic, to show that a legal code already in flight is discarded.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;
    localparam int WORD_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int CODE_W  = 5;

    typedef enum logic [3:0] {
        PAT_NONE,
        PAT_MIX_HI,
        PAT_MIX_LO,
        PAT_PACK_ODD,
        PAT_PACK_EVEN,
        PAT_BFLY,
        PAT_REP_UP,
        PAT_REP_LOW,
        PAT_UNPK_SX
    } pat_e;
endpackage

// File: rtl/shuffle_decode.sv
module shuffle_decode
    import lane_shuffle_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0] code_i,
    output logic          half_o,
    output pat_e          pat_o,
    output logic          bad_o
);
    always_comb begin
        half_o = 1'b0;
        pat_o  = PAT_NONE;
        if (code_i[1:0] == 2'b01) begin
            half_o = 1'b1;
            case (code_i[4:2])
                3'd0:    pat_o = PAT_MIX_HI;
                3'd1:    pat_o = PAT_MIX_LO;
                3'd2:    pat_o = PAT_PACK_ODD;
                3'd4:    pat_o = PAT_BFLY;
                3'd6:    pat_o = PAT_REP_UP;
                3'd7:    pat_o = PAT_REP_LOW;
                default: pat_o = PAT_NONE;
            endcase
        end else if (!code_i[0]) begin
            case (code_i[4:1])
                4'd1, 4'd6: pat_o = PAT_MIX_HI;
                4'd2, 4'd7: pat_o = PAT_MIX_LO;
                4'd3:       pat_o = PAT_UNPK_SX;
                4'd4:       pat_o = PAT_PACK_ODD;
                4'd5:       pat_o = PAT_PACK_EVEN;
                default:    pat_o = PAT_NONE;
            endcase
        end
        bad_o = (pat_o == PAT_NONE);
    end
endmodule

// File: rtl/lane_permute.sv
module lane_permute
    import lane_shuffle_pkg::*;
#(
    parameter int WW    = WORD_W,
    parameter int LANEW = BYTE_W
) (
    input  logic [WW-1:0] s_i,
    input  logic [WW-1:0] t_i,
    input  pat_e          pat_i,
    output logic [WW-1:0] res_o
);
    localparam int NL = WW / LANEW;
    localparam int HL = NL / 2;

    logic [NL-1:0][LANEW-1:0] sl, tl;
    logic [NL-1:0][LANEW-1:0] mix_hi, mix_lo, pack_odd, pack_even;
    logic [NL-1:0][LANEW-1:0] bfly, rep_up, rep_low, unpk;

    assign sl = s_i;
    assign tl = t_i;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        if ((k % 2) == 0) begin : g_even
            assign mix_hi[k] = tl[HL + k/2];
            assign mix_lo[k] = tl[k/2];
            assign bfly[k]   = tl[k+1];
            assign unpk[k]   = sl[k/2];
        end else begin : g_odd
            assign mix_hi[k] = sl[HL + k/2];
            assign mix_lo[k] = sl[k/2];
            assign bfly[k]   = sl[k-1];
            assign unpk[k]   = {LANEW{sl[k/2][LANEW-1]}};
        end
        if (k < HL) begin : g_lowhalf
            assign pack_odd[k]  = tl[2*k + 1];
            assign pack_even[k] = tl[2*k];
            assign rep_up[k]    = tl[HL + k];
            assign rep_low[k]   = tl[k];
        end else begin : g_uphalf
            assign pack_odd[k]  = sl[2*(k-HL) + 1];
            assign pack_even[k] = sl[2*(k-HL)];
            assign rep_up[k]    = sl[k];
            assign rep_low[k]   = sl[k-HL];
        end
    end

    always_comb begin
        case (pat_i)
            PAT_MIX_HI:    res_o = mix_hi;
            PAT_MIX_LO:    res_o = mix_lo;
            PAT_PACK_ODD:  res_o = pack_odd;
            PAT_PACK_EVEN: res_o = pack_even;
            PAT_BFLY:      res_o = bfly;
            PAT_REP_UP:    res_o = rep_up;
            PAT_REP_LOW:   res_o = rep_low;
            PAT_UNPK_SX:   res_o = unpk;
            default:       res_o = '0;
        endcase
    end
endmodule

// File: rtl/lane_shuffle.sv
module lane_shuffle
    import lane_shuffle_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic [WW-1:0]     s_i,
    input  logic [WW-1:0]     t_i,
    output logic [WW-1:0]     res_o,
    output logic              illegal_o
);
    typedef struct packed {
        logic [WW-1:0] res;
        logic          bad;
    } out_t;

    logic          is_half;
    logic          code_bad;
    pat_e          pat;
    logic [WW-1:0] res_byte, res_half;
    out_t          out_d, out_q;

    shuffle_decode #(.CW(CODE_W)) i_decode (
        .code_i (code_i),
        .half_o (is_half),
        .pat_o  (pat),
        .bad_o  (code_bad)
    );

    lane_permute #(.WW(WW), .LANEW(BYTE_W)) i_perm_byte (
        .s_i   (s_i),
        .t_i   (t_i),
        .pat_i (pat),
        .res_o (res_byte)
    );

    lane_permute #(.WW(WW), .LANEW(HALF_W)) i_perm_half (
        .s_i   (s_i),
        .t_i   (t_i),
        .pat_i (pat),
        .res_o (res_half)
    );

    always_comb begin
        out_d.bad = code_bad;
        if (code_bad)
            out_d.res = '0;
        else if (is_half)
            out_d.res = res_half;
        else
            out_d.res = res_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign res_o     = out_q.res;
    assign illegal_o = out_q.bad;

    AST_BAD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i[1:0] == 2'b11) |=> (illegal_o && res_o == '0)); // R1
    AST_HALF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i[1:0] == 2'b01 && code_i[4:2] != 3'd3 && code_i[4:2] != 3'd5) |=> !illegal_o); // R2
    AST_HALF_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i[1:0] == 2'b01 && (code_i[4:2] == 3'd3 || code_i[4:2] == 3'd5)) |=> (illegal_o && res_o == '0)); // R5
    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 5'b00110) |=> (res_o[15:8] == {8{$past(s_i[7])}})); // R6
    AST_BYTE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_i[0] && (code_i[4:1] == 4'd0 || code_i[4])) |=> illegal_o); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !illegal_o)); // R10
endmodule

// File: tb/test_lane_shuffle.sv
module test_lane_shuffle;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  code = '0;
    logic [63:0] s = '0, t = '0;
    logic [63:0] res;
    logic        illegal;
    int          checks = 0;
    int          fails = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2 clk = ~clk;

    lane_shuffle i_lane_shuffle (
        .clk(clk), .rst_n(rst_n), .code_i(code), .s_i(s), .t_i(t),
        .res_o(res), .illegal_o(illegal)
    );

    function automatic logic [15:0] hw(logic [63:0] v, int i);
        return v[16*i +: 16];
    endfunction
    function automatic logic [7:0] by(logic [63:0] v, int i);
        return v[8*i +: 8];
    endfunction
    function automatic logic [7:0] fx(logic [63:0] v, int i);
        return v[8*i + 7] ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [64:0] model(logic [4:0] c, logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        logic        bad;
        r = '0;
        bad = 1'b0;
        if (c[1:0] == 2'b11) bad = 1'b1;
        else if (c[1:0] == 2'b01) begin
            case (c[4:2])
                0: r = {hw(a,3), hw(b,3), hw(a,2), hw(b,2)};
                1: r = {hw(a,1), hw(b,1), hw(a,0), hw(b,0)};
                2: r = {hw(a,3), hw(a,1), hw(b,3), hw(b,1)};
                4: r = {hw(a,2), hw(b,3), hw(a,0), hw(b,1)};
                6: r = {hw(a,3), hw(a,2), hw(b,3), hw(b,2)};
                7: r = {hw(a,1), hw(a,0), hw(b,1), hw(b,0)};
                default: bad = 1'b1;
            endcase
        end else begin
            case (c[4:1])
                3: r = {fx(a,3), by(a,3), fx(a,2), by(a,2), fx(a,1), by(a,1), fx(a,0), by(a,0)};
                4: r = {by(a,7), by(a,5), by(a,3), by(a,1), by(b,7), by(b,5), by(b,3), by(b,1)};
                5: r = {by(a,6), by(a,4), by(a,2), by(a,0), by(b,6), by(b,4), by(b,2), by(b,0)};
                1, 6: r = {by(a,7), by(b,7), by(a,6), by(b,6), by(a,5), by(b,5), by(a,4), by(b,4)};
                2, 7: r = {by(a,3), by(b,3), by(a,2), by(b,2), by(a,1), by(b,1), by(a,0), by(b,0)};
                default: bad = 1'b1;
            endcase
        end
        return {bad, r};
    endfunction

    function automatic string tag_of(logic [4:0] c);
        if (c[1:0] == 2'b11) return "R1";
        if (c[1:0] == 2'b01) begin
            case (c[4:2])
                0, 1: return "R2";
                2, 4: return "R3";
                6, 7: return "R4";
                default: return "R5";
            endcase
        end
        case (c[4:1])
            3: return "R6";
            4, 5: return "R7";
            1, 2, 6, 7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(string tag, logic [63:0] exp_r, logic exp_b);
        checks++;
        if (res !== exp_r || illegal !== exp_b) begin
            fails++;
            $display("FAIL %s code=%b actual=%h/%b expected=%h/%b", tag, code, res, illegal, exp_r, exp_b);
        end
    endtask

    task automatic apply(logic [4:0] c, logic [63:0] a, logic [63:0] b, string tag);
        logic [64:0] e;
        code = c; s = a; t = b;
        e = model(c, a, b);
        @(negedge clk);
        compare(tag, e[63:0], e[64]);
    endtask

    function automatic logic [63:0] next_rng(logic [63:0] v);
        logic [63:0] x;
        x = v ^ (v << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [63:0] SNUM = 64'h8786_8584_0302_0100;
    localparam logic [63:0] TNUM = 64'h1716_1514_9392_9190;

    initial begin
        code = 5'b01110; s = '1; t = '1;
        repeat (3) @(negedge clk);
        compare("R10", 64'h0, 1'b0);
        rst_n = 1'b1;
        apply(5'b01110, SNUM, TNUM, "R11");
        apply(5'b00101, 64'h0004_0003_0002_0001, 64'h0040_0030_0020_0010, "R11");
        apply(5'b00001, SNUM, TNUM, "R2");
        apply(5'b00101, SNUM, TNUM, "R2");
        apply(5'b01001, SNUM, TNUM, "R3");
        apply(5'b10001, SNUM, TNUM, "R3");
        apply(5'b11001, SNUM, TNUM, "R4");
        apply(5'b11101, SNUM, TNUM, "R4");
        apply(5'b01101, '1, '1, "R5");
        apply(5'b10101, '1, '1, "R5");
        apply(5'b00110, 64'h0000_0000_807F_FF00, TNUM, "R6");
        apply(5'b00110, 64'hFFFF_FFFF_0180_7F81, '1, "R6");
        apply(5'b01000, SNUM, TNUM, "R7");
        apply(5'b01010, SNUM, TNUM, "R7");
        apply(5'b01100, SNUM, TNUM, "R8");
        apply(5'b00010, SNUM, TNUM, "R8");
        apply(5'b01110, SNUM, TNUM, "R8");
        apply(5'b00100, SNUM, TNUM, "R8");
        apply(5'b00000, '1, '1, "R9");
        apply(5'b11110, '1, '1, "R9");
        apply(5'b00011, '1, '1, "R1");
        apply(5'b11111, '1, '1, "R1");
        code = 5'b00001; s = '1; t = '1;
        rst_n = 1'b0;
        @(negedge clk);
        compare("R10", 64'h0, 1'b0);
        rst_n = 1'b1;
        for (int c = 0; c < 32; c++) begin
            apply(5'(c), SNUM, TNUM, tag_of(5'(c)));
            apply(5'(c), '1, 64'h0, tag_of(5'(c)));
            for (int n = 0; n < 20; n++) begin
                logic [63:0] a;
                rng = next_rng(rng); a = rng;
                rng = next_rng(rng);
                apply(5'(c), a, rng, tag_of(5'(c)));
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule